// File: doc/BRIEF.md
# Dual-Clock Sample Stream FIFO

This block carries a stream of fixed-width samples from a fast source clock domain into a slower destination clock domain. Each sample is written into a small memory on the source clock and read from it on the destination clock. The sample bits never pass through a synchronizer. The only signals that cross between the domains are the two ring pointers. Each pointer is kept in Gray code and passes through its own multi-flop synchronizer. A pointer advances by one position per step, so only one of its bits changes at a time. The sampled copy in the other domain is therefore always either the old value or the new value.

The source side is push-only. The source raises `src_push` together with a sample whenever it has one, and the block applies no backpressure. A push that arrives while all entries are occupied is discarded, and the block reports it on `src_overrun` one source cycle later. The destination side drains the memory by itself. In every destination cycle in which the memory holds data, it takes the oldest entry and presents it on `dst_sample` with `dst_strobe` high for that one cycle. Any sticky collection of overrun events is left to the surrounding logic.

Top module: `stream_cdc_fifo`

## Requirements
- R1: While `src_rst_n` and `dst_rst_n` are low, and after both are released with no push, `dst_strobe` and `src_overrun` are 0 and no sample is delivered.
- R2: Every accepted sample is delivered exactly once and in push order. Each delivery is marked by `dst_strobe` being high for one `dst_clk` cycle. When pushes are spaced three or more destination cycles apart, `dst_strobe` is never high in two consecutive cycles.
- R3: Every delivered sample is bit-exact. Consecutive samples alternating between 18'h00000 and 18'h3FFFF arrive as exactly those values, and no other value is ever shown with `dst_strobe`.
- R4: The write pointer and the read pointer each change in at most one Gray bit per cycle of their own clock.
- R5: With DEPTH (default 16) entries held, a push is discarded and the write pointer does not move. `src_overrun` is high for exactly one `src_clk` cycle per discarded push, in the cycle after that push. The number of pushes equals the number of deliveries plus the number of overrun pulses.
- R6: No overrun occurs while fewer than DEPTH samples are outstanding. In particular, none of the first DEPTH pushes after the FIFO is empty overruns, and none occurs when the push rate is at or below the destination clock rate.
- R7: A read takes place only when the FIFO is not empty. After the source stops, every stored sample is delivered and `dst_strobe` then stays 0.
- R8: Asserting both resets in the middle of a stream empties the FIFO. No sample pushed before the reset is delivered afterwards, and samples pushed after the reset pass correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Source (write) clock |
| src_rst_n | input | 1 | Source-domain reset, active low, asynchronous |
| src_push | input | 1 | Sample present this source cycle |
| src_sample | input | DATA_W | Sample to store |
| src_overrun | output | 1 | One-cycle pulse: previous push was discarded (FIFO full) |
| dst_clk | input | 1 | Destination (read) clock |
| dst_rst_n | input | 1 | Destination-domain reset, active low, asynchronous |
| dst_sample | output | DATA_W | Delivered sample, held between deliveries |
| dst_strobe | output | 1 | One-cycle pulse per delivered sample |

## Verification
The main function is driven with five patterns. A single isolated sample shows that the delivery path works from an empty state. A sparse stream that alternates all-zeros and all-ones shows that data integrity and single-cycle strobes hold when every bit flips. A stream at exactly the destination rate shows that the block loses nothing when rates match. A continuous burst at the full source rate fills the memory and separates correct discard accounting from silent loss or duplication. A reset in the middle of a stream shows that stale entries are dropped while later ones still flow.

// File: rtl/cdcf_pkg.sv
package cdcf_pkg;
   localparam int MIN_DEPTH       = 4;
   localparam int MIN_SYNC_STAGES = 2;

   function automatic bit is_pow2(input int value);
      return (value > 0) && ((value & (value - 1)) == 0);
   endfunction
endpackage

// File: rtl/cdcf_sync.sv
module cdcf_sync #(
   parameter int W      = 5,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [STAGES-1:0][W-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/cdcf_mem.sv
module cdcf_mem #(
   parameter int W  = 18,
   parameter int AW = 4
) (
   input  logic          wclk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [W-1:0]  wdata,
   input  logic [AW-1:0] raddr,
   output logic [W-1:0]  rdata
);
   localparam int ENTRIES = 1 << AW;

   logic [W-1:0] store [ENTRIES];

   always_ff @(posedge wclk) begin
      if (we) store[waddr] <= wdata;
   end

   assign rdata = store[raddr];
endmodule

// File: rtl/cdcf_wr_ctl.sv
module cdcf_wr_ctl #(
   parameter int AW = 4
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        push,
   input  logic [AW:0] rgray_s,
   output logic [AW:0] wgray,
   output logic [AW-1:0] waddr,
   output logic        we,
   output logic        overrun
);
   localparam int PW    = AW + 1;
   localparam int DEPTH = 1 << AW;

   logic [PW-1:0] wbin, wbin_nxt, rbin_s, occupancy;
   logic          full;

   assign wbin_nxt = wbin + 1'b1;
   assign full     = (wgray == {~rgray_s[PW-1:PW-2], rgray_s[PW-3:0]});
   assign we       = push & ~full;
   assign waddr    = wbin[AW-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wbin    <= '0;
         wgray   <= '0;
         overrun <= 1'b0;
      end else begin
         overrun <= push & full;
         if (we) begin
            wbin  <= wbin_nxt;
            wgray <= wbin_nxt ^ (wbin_nxt >> 1);
         end
      end
   end

   always_comb begin
      for (int i = 0; i < PW; i++) rbin_s[i] = ^(rgray_s >> i);
   end
   assign occupancy = wbin - rbin_s;

   assert_hold_when_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full) |=> ($stable(wbin) && overrun));
   assert_wr_gray_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(wgray ^ $past(wgray)) <= 1);
   assert_wr_occupancy_R6: assert property (@(posedge clk) disable iff (!rst_n)
      occupancy <= PW'(DEPTH));
endmodule

// File: rtl/cdcf_rd_ctl.sv
module cdcf_rd_ctl #(
   parameter int W  = 18,
   parameter int AW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW:0]   wgray_s,
   input  logic [W-1:0]  rdata,
   output logic [AW:0]   rgray,
   output logic [AW-1:0] raddr,
   output logic [W-1:0]  sample,
   output logic          strobe
);
   localparam int PW    = AW + 1;
   localparam int DEPTH = 1 << AW;

   logic [PW-1:0] rbin, rbin_nxt, wbin_s, occupancy;
   logic          empty;

   assign empty    = (rgray == wgray_s);
   assign rbin_nxt = rbin + 1'b1;
   assign raddr    = rbin[AW-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rbin   <= '0;
         rgray  <= '0;
         sample <= '0;
         strobe <= 1'b0;
      end else begin
         strobe <= ~empty;
         if (!empty) begin
            sample <= rdata;
            rbin   <= rbin_nxt;
            rgray  <= rbin_nxt ^ (rbin_nxt >> 1);
         end
      end
   end

   always_comb begin
      for (int i = 0; i < PW; i++) wbin_s[i] = ^(wgray_s >> i);
   end
   assign occupancy = wbin_s - rbin;

   assert_no_read_when_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
      empty |=> (!strobe && $stable(rgray)));
   assert_sample_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !strobe |-> $stable(sample));
   assert_rd_gray_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(rgray ^ $past(rgray)) <= 1);
   assert_rd_occupancy_R6: assert property (@(posedge clk) disable iff (!rst_n)
      occupancy <= PW'(DEPTH));
endmodule

// File: rtl/stream_cdc_fifo.sv
module stream_cdc_fifo #(
   parameter int DATA_W      = 18,
   parameter int DEPTH       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              src_clk,
   input  logic              src_rst_n,
   input  logic              src_push,
   input  logic [DATA_W-1:0] src_sample,
   output logic              src_overrun,
   input  logic              dst_clk,
   input  logic              dst_rst_n,
   output logic [DATA_W-1:0] dst_sample,
   output logic              dst_strobe
);
   import cdcf_pkg::*;

   localparam int AW = $clog2(DEPTH);
   localparam int PW = AW + 1;

   generate
      if (!is_pow2(DEPTH) || DEPTH < MIN_DEPTH) begin : g_bad_depth
         $error("stream_cdc_fifo: DEPTH must be a power of two and at least 4");
      end
      if (SYNC_STAGES < MIN_SYNC_STAGES) begin : g_bad_sync
         $error("stream_cdc_fifo: SYNC_STAGES must be at least 2");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("stream_cdc_fifo: DATA_W must be positive");
      end
   endgenerate

   logic [PW-1:0]     wgray, rgray, wgray_s, rgray_s;
   logic [AW-1:0]     waddr, raddr;
   logic              we;
   logic [DATA_W-1:0] rdata;

   cdcf_wr_ctl #(.AW(AW)) u_wr (
      .clk(src_clk), .rst_n(src_rst_n), .push(src_push), .rgray_s(rgray_s),
      .wgray(wgray), .waddr(waddr), .we(we), .overrun(src_overrun)
   );

   cdcf_mem #(.W(DATA_W), .AW(AW)) u_mem (
      .wclk(src_clk), .we(we), .waddr(waddr), .wdata(src_sample),
      .raddr(raddr), .rdata(rdata)
   );

   cdcf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_sync_w2r (
      .clk(dst_clk), .rst_n(dst_rst_n), .d(wgray), .q(wgray_s)
   );

   cdcf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_sync_r2w (
      .clk(src_clk), .rst_n(src_rst_n), .d(rgray), .q(rgray_s)
   );

   cdcf_rd_ctl #(.W(DATA_W), .AW(AW)) u_rd (
      .clk(dst_clk), .rst_n(dst_rst_n), .wgray_s(wgray_s), .rdata(rdata),
      .rgray(rgray), .raddr(raddr), .sample(dst_sample), .strobe(dst_strobe)
   );
endmodule

// File: tb/tb_stream_cdc_fifo.sv
module tb_stream_cdc_fifo;
   localparam int W     = 18;
   localparam int DEPTH = 16;

   logic         src_clk = 1'b0, dst_clk = 1'b0;
   logic         src_rst_n = 1'b0, dst_rst_n = 1'b0;
   logic         src_push = 1'b0;
   logic [W-1:0] src_sample = '0;
   logic         src_overrun;
   logic [W-1:0] dst_sample;
   logic         dst_strobe;

   always #2 src_clk = ~src_clk;             // 250 MHz source
   initial begin
      #3;
      forever #8 dst_clk = ~dst_clk;         // 4:1 slower destination
   end

   stream_cdc_fifo #(.DATA_W(W), .DEPTH(DEPTH), .SYNC_STAGES(2)) dut (
      .src_clk(src_clk), .src_rst_n(src_rst_n), .src_push(src_push),
      .src_sample(src_sample), .src_overrun(src_overrun),
      .dst_clk(dst_clk), .dst_rst_n(dst_rst_n),
      .dst_sample(dst_sample), .dst_strobe(dst_strobe)
   );

   logic [W-1:0] exp_q [$];
   int  checks = 0, fails = 0;
   int  delivered = 0, overruns = 0, pushes = 0;
   int  back_to_back = 0;
   int  early_overrun = 0;
   bit  last_pushed = 1'b0;
   bit  prev_strobe = 1'b0;
   bit  done = 1'b0;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Driver: one call per source cycle; accounts for the overrun of the previous push.
   task automatic src_cycle(input bit push, input logic [W-1:0] val);
      @(negedge src_clk);
      if (src_overrun) begin
         if (!last_pushed) check(1'b0, "R5 overrun without push", 1, 0);
         else begin
            overruns++;
            void'(exp_q.pop_back());
         end
      end
      last_pushed = push;
      src_push    = push;
      src_sample  = val;
      if (push) begin
         pushes++;
         exp_q.push_back(val);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) src_cycle(1'b0, '0);
   endtask

   task automatic reset_counts();
      delivered = 0; overruns = 0; pushes = 0; back_to_back = 0;
   endtask

   // Monitor: compares each delivered sample with the scoreboard head.
   always @(negedge dst_clk) begin
      if (dst_strobe) begin
         if (prev_strobe) back_to_back++;
         if (exp_q.size() == 0) check(1'b0, "R2 unexpected strobe", int'(dst_sample), -1);
         else begin
            logic [W-1:0] e;
            e = exp_q.pop_front();
            delivered++;
            check(dst_sample == e, "R3 sample value", int'(dst_sample), int'(e));
         end
      end
      prev_strobe = dst_strobe;
   end

   initial begin
      #400000;
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      repeat (5) @(negedge dst_clk);
      check(dst_strobe == 1'b0, "R1 strobe in reset", dst_strobe, 0);
      check(src_overrun == 1'b0, "R1 overrun in reset", src_overrun, 0);
      @(negedge src_clk);
      src_rst_n = 1'b1; dst_rst_n = 1'b1;
      idle(60);
      check(delivered == 0, "R1 nothing delivered after reset", delivered, 0);

      // R2: single sample
      reset_counts();
      src_cycle(1'b1, 18'h12345);
      idle(60);
      check(delivered == 1, "R2 single sample delivered", delivered, 1);
      check(exp_q.size() == 0, "R2 scoreboard empty", exp_q.size(), 0);

      // R3: all-zeros / all-ones alternation, sparse (12 source cycles = 3 destination cycles)
      reset_counts();
      for (int i = 0; i < 20; i++) begin
         src_cycle(1'b1, (i % 2 == 0) ? 18'h00000 : 18'h3FFFF);
         idle(11);
      end
      idle(60);
      check(delivered == 20, "R3 alternation count", delivered, 20);
      check(overruns == 0, "R6 no overrun sparse", overruns, 0);
      check(back_to_back == 0, "R2 single-cycle strobes", back_to_back, 0);

      // R6: matched-rate stream (one push per destination cycle)
      reset_counts();
      for (int i = 0; i < 40; i++) begin
         src_cycle(1'b1, W'(i * 4099 + 7));
         idle(3);
      end
      idle(80);
      check(overruns == 0, "R6 no overrun matched rate", overruns, 0);
      check(delivered == 40, "R6 matched rate delivered", delivered, 40);

      // R5: continuous burst at full source rate
      reset_counts();
      for (int i = 0; i < 100; i++) begin
         src_cycle(1'b1, W'(i * 2731 + 3));
         if (i == DEPTH) early_overrun = overruns;
      end
      idle(1);
      check(early_overrun == 0, "R6 first DEPTH pushes accepted", early_overrun, 0);
      check(overruns > 0, "R5 overrun on full", overruns, 1);
      check(pushes - overruns >= DEPTH, "R5 accepted at least DEPTH", pushes - overruns, DEPTH);

      // R7: drain to empty
      idle(500);
      check(exp_q.size() == 0, "R7 drained", exp_q.size(), 0);
      check(delivered + overruns == pushes, "R5 pushes = deliveries + overruns",
            delivered + overruns, pushes);
      @(negedge dst_clk);
      check(dst_strobe == 1'b0, "R7 strobe idle after drain", dst_strobe, 0);

      // R8: reset in mid-stream
      for (int i = 0; i < 30; i++) src_cycle(1'b1, W'(18'h2AAAA ^ i));
      @(negedge src_clk);
      src_push = 1'b0; last_pushed = 1'b0;
      src_rst_n = 1'b0; dst_rst_n = 1'b0;
      exp_q.delete();
      reset_counts();
      repeat (4) @(negedge dst_clk);
      check(src_overrun == 1'b0, "R8 overrun cleared", src_overrun, 0);
      @(negedge src_clk);
      src_rst_n = 1'b1; dst_rst_n = 1'b1;
      idle(100);
      check(delivered == 0, "R8 no stale samples", delivered, 0);
      for (int i = 0; i < 5; i++) begin
         src_cycle(1'b1, W'(18'h15555 + i));
         idle(11);
      end
      idle(80);
      check(delivered == 5, "R8 new samples pass", delivered, 5);
      check(exp_q.size() == 0, "R8 scoreboard empty", exp_q.size(), 0);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule